// File: doc/BRIEF.md
# Single-Bank Row-Hit-First Command Scheduler

This block sits between a request source and one DRAM bank. It keeps a small pool of pending accesses, each carrying a row, a column and a read/write flag. It tracks which row is currently latched in the bank's sense amplifiers. On every cycle it decides whether to issue one command to the bank, and which one. The four commands are open a row, read a column, write a column, and close the row.

Requests that target the open row are served first, and the oldest request wins within any group. A column command that can go now is always preferred over opening or closing a row. A policy input selects how the row is managed after an access. It can stay open, in the hope that the next access uses the same row. Or it can be closed as soon as no queued request needs it. Down-counters hold back each command until the bank's minimum spacing rules are met. Requests enter through a valid/ready handshake. Commands leave on a single output with their row and column.

Top module: `sched_frfcfs`

## Requirements
- R1: While a row is open, a queued request to that row is served before any request to another row, even an older one.
- R2: Among requests of equal standing (all hits, or all misses), the one that arrived first is served first.
- R3: When a read or write can legally issue, it is issued in preference to any open-row or close-row command.
- R4: With `close_policy` low, the row stays open after an access. A request to another row is served by close, open, then the column command. When the pool is empty, no command issues.
- R5: With `close_policy` high, the row is closed right after an access, unless a queued request still targets that row. In that case the column commands to the row are issued first.
- R6: `cmd_kind` encodes 0 = open row, 1 = read, 2 = write, 3 = close row. `cmd_row` carries the row for every command. For a read or write it is the open row. `cmd_col` carries the request's column for reads and writes, and zero for the row commands.
- R7: Two open-row commands are separated by at least `T_RC` cycles.
- R8: A read issues no earlier than `T_WTR` cycles after a write.
- R9: A read or write issues at least `T_RCD` cycles after the open-row command, and an open-row command at least `T_RP` cycles after a close-row command.
- R10: `req_ready` is low exactly when `DEPTH` requests are held. A request offered while it is low is dropped and never produces a command.
- R11: After reset the bank is treated as closed, the pool is empty, `req_ready` is high and no command issues.
- R12: Every accepted request receives exactly one read or write, and is then removed. An open-row command goes only to a closed bank, and reads, writes and close-row commands only to an open one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| close_policy | input | 1 | 0 keeps the row open after an access, 1 closes it |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The pool can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | A command issues on this cycle's rising edge |
| cmd_kind | output | 2 | Command code (see R6) |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of a read or write, else zero |

## Verification
The bench builds the scheduler with a four-entry pool, so a handful of back-to-back requests fills it and the ready drop and the dropped request can be seen. The timing parameters are T_RCD = 2, T_RP = 2, T_RC = 7 and T_WTR = 3. With them the open-to-open gap is the rule that binds after a short access to a closed row. A read queued behind a write to the same row waits three cycles. Each policy runs in its own scenario, and the command stream and the cycle of every command are compared against tables worked out from the requirements.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Command codes placed on cmd_kind
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_kind_e;

endpackage

// File: rtl/sched_req_buf.sv
// Request pool: storage per slot plus a pairwise age matrix.
// older_o[i][j] is set when slot i arrived before slot j (only meaningful
// when both slots are valid).
module sched_req_buf #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 14,
  parameter int COL_W = 11
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            push_i,
  input  logic                            push_wr_i,
  input  logic [ROW_W-1:0]                push_row_i,
  input  logic [COL_W-1:0]                push_col_i,
  input  logic [DEPTH-1:0]                pop_mask_i,
  output logic [DEPTH-1:0]                valid_o,
  output logic [DEPTH-1:0]                wr_o,
  output logic [DEPTH-1:0][ROW_W-1:0]     row_o,
  output logic [DEPTH-1:0][COL_W-1:0]     col_o,
  output logic [DEPTH-1:0][DEPTH-1:0]     older_o,
  output logic                            full_o
);

  logic [DEPTH-1:0]            valid_q, valid_d, load;
  logic [DEPTH-1:0]            wr_q;
  logic [DEPTH-1:0][ROW_W-1:0] row_q;
  logic [DEPTH-1:0][COL_W-1:0] col_q;
  logic [DEPTH-1:0][DEPTH-1:0] older_q, older_d;

  // lowest free slot takes the incoming request
  always_comb begin
    logic found;
    load  = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_q[i] && !found) begin
        load[i] = push_i;
        found   = 1'b1;
      end
    end
  end

  assign full_o  = &valid_q;
  assign valid_d = (valid_q & ~pop_mask_i) | load;

  // a new arrival is younger than every slot present
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (load[i])      older_d[i][j] = 1'b0;
        else if (load[j]) older_d[i][j] = 1'b1;
        else              older_d[i][j] = older_q[i][j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      older_q <= '0;
    end else begin
      valid_q <= valid_d;
      older_q <= older_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (load[i]) begin
          wr_q[i]  <= push_wr_i;
          row_q[i] <= push_row_i;
          col_q[i] <= push_col_i;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign wr_o    = wr_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
  assign older_o = older_q;

endmodule

// File: rtl/sched_picker.sv
// Combinational command choice: ready row hits (oldest first), then a
// row command for the oldest pending request.
module sched_picker
  import sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ROW_W = 14,
  parameter int COL_W = 11
) (
  input  logic [DEPTH-1:0]                valid_i,
  input  logic [DEPTH-1:0]                wr_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]     row_i,
  input  logic [DEPTH-1:0][COL_W-1:0]     col_i,
  input  logic [DEPTH-1:0][DEPTH-1:0]     older_i,
  input  logic                            bank_open_i,
  input  logic [ROW_W-1:0]                open_row_i,
  input  logic                            close_policy_i,
  input  logic                            col_ok_i,
  input  logic                            rd_ok_i,
  input  logic                            act_ok_i,
  output logic                            cmd_valid_o,
  output cmd_kind_e                       cmd_kind_o,
  output logic [ROW_W-1:0]                cmd_row_o,
  output logic [COL_W-1:0]                cmd_col_o,
  output logic [DEPTH-1:0]                retire_o
);

  function automatic logic [DEPTH-1:0] oldest_of(
    input logic [DEPTH-1:0]            set,
    input logic [DEPTH-1:0][DEPTH-1:0] older
  );
    logic [DEPTH-1:0] r;
    for (int i = 0; i < DEPTH; i++) begin
      r[i] = set[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && set[j] && !older[i][j]) r[i] = 1'b0;
      end
    end
    return r;
  endfunction

  logic [DEPTH-1:0] hit, col_ready, col_pick, act_pick;
  logic             sel_wr;
  logic [COL_W-1:0] sel_col;
  logic [ROW_W-1:0] act_row;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i]       = valid_i[i] && bank_open_i && (row_i[i] == open_row_i);
      col_ready[i] = hit[i] && col_ok_i && (wr_i[i] || rd_ok_i);
    end
  end

  assign col_pick = oldest_of(col_ready, older_i);
  assign act_pick = oldest_of(valid_i, older_i);

  always_comb begin
    sel_wr  = 1'b0;
    sel_col = '0;
    act_row = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (col_pick[i]) begin
        sel_wr  = sel_wr | wr_i[i];
        sel_col = sel_col | col_i[i];
      end
      if (act_pick[i]) act_row = act_row | row_i[i];
    end
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_kind_o  = CMD_ACT;
    cmd_row_o   = '0;
    cmd_col_o   = '0;
    retire_o    = '0;
    if (|col_ready) begin
      cmd_valid_o = 1'b1;
      cmd_kind_o  = sel_wr ? CMD_WR : CMD_RD;
      cmd_row_o   = open_row_i;
      cmd_col_o   = sel_col;
      retire_o    = col_pick;
    end else if (bank_open_i) begin
      if (!(|hit) && ((|valid_i) || close_policy_i)) begin
        cmd_valid_o = 1'b1;
        cmd_kind_o  = CMD_PRE;
        cmd_row_o   = open_row_i;
      end
    end else if ((|valid_i) && act_ok_i) begin
      cmd_valid_o = 1'b1;
      cmd_kind_o  = CMD_ACT;
      cmd_row_o   = act_row;
    end
  end

endmodule

// File: rtl/sched_timer.sv
// One down-counter per spacing rule; a rule is met when its counter is zero.
module sched_gap_cnt #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic ok_o
);
  localparam int W = (GAP > 1) ? $clog2(GAP) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)           cnt_d = W'(GAP - 1);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ok_o = (cnt_q == '0);
endmodule

module sched_timer #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 10,
  parameter int T_WTR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic pre_i,
  input  logic wr_i,
  output logic act_ok_o,
  output logic col_ok_o,
  output logic rd_ok_o
);
  localparam int NRULE = 4;
  localparam int GAPS [NRULE] = '{T_RCD, T_RP, T_RC, T_WTR};

  logic [NRULE-1:0] load, ok;

  // rule 0: open->column, 1: close->open, 2: open->open, 3: write->read
  assign load = {wr_i, act_i, pre_i, act_i};

  for (genvar g = 0; g < NRULE; g++) begin : g_rule
    sched_gap_cnt #(.GAP(GAPS[g])) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load[g]),
      .ok_o   (ok[g])
    );
  end

  assign col_ok_o = ok[0];
  assign act_ok_o = ok[1] & ok[2];
  assign rd_ok_o  = ok[3];
endmodule

// File: rtl/sched_frfcfs.sv
module sched_frfcfs
  import sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ROW_W = 14,
  parameter int COL_W = 11,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 10,
  parameter int T_WTR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_policy,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col
);

  logic [DEPTH-1:0]            valid, wr, retire;
  logic [DEPTH-1:0][ROW_W-1:0] row;
  logic [DEPTH-1:0][COL_W-1:0] col;
  logic [DEPTH-1:0][DEPTH-1:0] older;
  logic                        full, push;
  logic                        act_ok, col_ok, rd_ok;
  logic                        open_q, open_d;
  logic [ROW_W-1:0]            open_row_q, open_row_d;
  cmd_kind_e                   pick_kind;
  logic                        is_act, is_pre, is_wr;

  assign req_ready = !full;
  assign push      = req_valid && req_ready;

  sched_req_buf #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .push_wr_i  (req_write),
    .push_row_i (req_row),
    .push_col_i (req_col),
    .pop_mask_i (retire),
    .valid_o    (valid),
    .wr_o       (wr),
    .row_o      (row),
    .col_o      (col),
    .older_o    (older),
    .full_o     (full)
  );

  sched_picker #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_pick (
    .valid_i        (valid),
    .wr_i           (wr),
    .row_i          (row),
    .col_i          (col),
    .older_i        (older),
    .bank_open_i    (open_q),
    .open_row_i     (open_row_q),
    .close_policy_i (close_policy),
    .col_ok_i       (col_ok),
    .rd_ok_i        (rd_ok),
    .act_ok_i       (act_ok),
    .cmd_valid_o    (cmd_valid),
    .cmd_kind_o     (pick_kind),
    .cmd_row_o      (cmd_row),
    .cmd_col_o      (cmd_col),
    .retire_o       (retire)
  );

  assign cmd_kind = pick_kind;
  assign is_act   = cmd_valid && (pick_kind == CMD_ACT);
  assign is_pre   = cmd_valid && (pick_kind == CMD_PRE);
  assign is_wr    = cmd_valid && (pick_kind == CMD_WR);

  sched_timer #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_WTR(T_WTR)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (is_act),
    .pre_i    (is_pre),
    .wr_i     (is_wr),
    .act_ok_o (act_ok),
    .col_ok_o (col_ok),
    .rd_ok_o  (rd_ok)
  );

  // bank row state
  always_comb begin
    open_d     = open_q;
    open_row_d = open_row_q;
    if (is_act) begin
      open_d     = 1'b1;
      open_row_d = cmd_row;
    end else if (is_pre) begin
      open_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else begin
      open_q <= open_d;
      if (is_act) open_row_q <= open_row_d;
    end
  end

endmodule

// File: rtl/sched_frfcfs_chk.sv
module sched_frfcfs_chk #(
  parameter int DEPTH = 8,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 10,
  parameter int T_WTR = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       close_policy,
  input logic       req_valid,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic [1:0] cmd_kind
);
  localparam int GMAX = (T_RC > T_WTR) ? ((T_RC > T_RCD) ? ((T_RC > T_RP) ? T_RC : T_RP)
                                                          : ((T_RCD > T_RP) ? T_RCD : T_RP))
                                       : ((T_WTR > T_RCD) ? ((T_WTR > T_RP) ? T_WTR : T_RP)
                                                          : ((T_RCD > T_RP) ? T_RCD : T_RP));
  localparam int CW = $clog2(GMAX + 2);
  localparam int OW = $clog2(DEPTH + 1);

  logic          c_act, c_rd, c_wr, c_pre, c_col;
  logic [OW-1:0] occ;
  logic          open_m;
  logic [CW-1:0] since_act, since_pre, since_wr;

  assign c_act = cmd_valid && (cmd_kind == 2'd0);
  assign c_rd  = cmd_valid && (cmd_kind == 2'd1);
  assign c_wr  = cmd_valid && (cmd_kind == 2'd2);
  assign c_pre = cmd_valid && (cmd_kind == 2'd3);
  assign c_col = c_rd || c_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ       <= '0;
      open_m    <= 1'b0;
      since_act <= '1;
      since_pre <= '1;
      since_wr  <= '1;
    end else begin
      occ <= occ + OW'(req_valid && req_ready) - OW'(c_col);
      if (c_act) open_m <= 1'b1;
      else if (c_pre) open_m <= 1'b0;
      since_act <= c_act ? CW'(1) : ((since_act != '1) ? since_act + 1'b1 : since_act);
      since_pre <= c_pre ? CW'(1) : ((since_pre != '1) ? since_pre + 1'b1 : since_pre);
      since_wr  <= c_wr  ? CW'(1) : ((since_wr  != '1) ? since_wr  + 1'b1 : since_wr);
    end
  end

  p_rc_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |-> since_act >= CW'(T_RC));
  p_wtr_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd |-> since_wr >= CW'(T_WTR));
  p_rcd_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_col |-> since_act >= CW'(T_RCD));
  p_rp_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |-> since_pre >= CW'(T_RP));
  p_ready_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (occ != OW'(DEPTH)));
  p_idle_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && !open_m) |-> !cmd_valid);
  p_open_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && !close_policy) |-> !cmd_valid);
  p_col_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
    c_col |-> (open_m && occ != '0));
  p_act_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |-> !open_m);
  p_pre_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
    c_pre |-> open_m);

endmodule

bind sched_frfcfs sched_frfcfs_chk #(
  .DEPTH (DEPTH),
  .T_RCD (T_RCD),
  .T_RP  (T_RP),
  .T_RC  (T_RC),
  .T_WTR (T_WTR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .close_policy (close_policy),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .cmd_valid    (cmd_valid),
  .cmd_kind     (cmd_kind)
);

// File: tb/sched_frfcfs_tb.sv
module sched_frfcfs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_DEPTH = 4;
  localparam int TB_RCD = 2;
  localparam int TB_RP  = 2;
  localparam int TB_RC  = 7;
  localparam int TB_WTR = 3;
  localparam int NEXP = 31;

  // expected command streams {kind[1:0], row[13:0], col[10:0]}
  // kind: 0 open row, 1 read, 2 write, 3 close row
  localparam logic [26:0] EXP [NEXP] = '{
    // scenario 0: keep-open policy
    {2'd0,14'd5,11'd0}, {2'd1,14'd5,11'd1}, {2'd2,14'd5,11'd2}, {2'd1,14'd5,11'd4},
    {2'd3,14'd5,11'd0}, {2'd0,14'd7,11'd0}, {2'd1,14'd7,11'd3},
    // scenario 1: close policy
    {2'd0,14'd3,11'd0}, {2'd1,14'd3,11'd0}, {2'd1,14'd3,11'd1}, {2'd3,14'd3,11'd0},
    {2'd0,14'd9,11'd0}, {2'd2,14'd9,11'd5}, {2'd3,14'd9,11'd0},
    {2'd0,14'd11,11'd0}, {2'd1,14'd11,11'd2}, {2'd3,14'd11,11'd0},
    // scenario 2: full pool, keep-open policy
    {2'd0,14'd1,11'd0}, {2'd1,14'd1,11'd0}, {2'd3,14'd1,11'd0},
    {2'd0,14'd2,11'd0}, {2'd1,14'd2,11'd1}, {2'd3,14'd2,11'd0},
    {2'd0,14'd3,11'd0}, {2'd1,14'd3,11'd2}, {2'd3,14'd3,11'd0},
    {2'd0,14'd4,11'd0}, {2'd1,14'd4,11'd3}, {2'd3,14'd4,11'd0},
    {2'd0,14'd6,11'd0}, {2'd1,14'd6,11'd4}
  };
  localparam int SC_BASE [3] = '{0, 7, 17};
  localparam int SC_LEN  [3] = '{7, 10, 14};

  logic        clk, rst_n, close_policy;
  logic        req_valid, req_ready, req_write;
  logic [13:0] req_row;
  logic [10:0] req_col;
  logic        cmd_valid;
  logic [1:0]  cmd_kind;
  logic [13:0] cmd_row;
  logic [10:0] cmd_col;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [26:0] log_q [128];
  int          stamp [128];
  int          log_n = 0;

  sched_frfcfs #(
    .DEPTH(TB_DEPTH), .ROW_W(14), .COL_W(11),
    .T_RCD(TB_RCD), .T_RP(TB_RP), .T_RC(TB_RC), .T_WTR(TB_WTR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .close_policy(close_policy),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row), .cmd_col(cmd_col)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // command recorder: the value seen at the falling edge issues at the next rise
  always @(negedge clk) begin
    if (rst_n && cmd_valid && log_n < 128) begin
      log_q[log_n] = {cmd_kind, cmd_row, cmd_col};
      stamp[log_n] = cyc;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic start_sc(input bit pol);
    rst_n = 1'b0;
    close_policy = pol;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_row = '0;
    req_col = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(cmd_valid == 1'b0, "R11", "no command after reset", int'(cmd_valid), 0);
    check(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);
  endtask

  task automatic push(input bit w, input int r, input int c);
    req_valid = 1'b1;
    req_write = w;
    req_row = 14'(r);
    req_col = 11'(c);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic verify(input int sc, input int base, input string tag);
    int n;
    int last_act, last_pre, last_wr;
    n = log_n - base;
    check(n == SC_LEN[sc], "R12", "command count", n, SC_LEN[sc]);
    for (int k = 0; k < SC_LEN[sc] && k < n; k++) begin
      check(log_q[base+k] == EXP[SC_BASE[sc]+k], tag, $sformatf("command %0d", k),
            int'(log_q[base+k]), int'(EXP[SC_BASE[sc]+k]));
    end
    last_act = -1000; last_pre = -1000; last_wr = -1000;
    for (int k = 0; k < n; k++) begin
      case (log_q[base+k][26:25])
        2'd0: begin
          check(stamp[base+k] - last_act >= TB_RC, "R7", "open-to-open gap",
                stamp[base+k] - last_act, TB_RC);
          check(stamp[base+k] - last_pre >= TB_RP, "R9", "close-to-open gap",
                stamp[base+k] - last_pre, TB_RP);
          last_act = stamp[base+k];
        end
        2'd1: begin
          check(stamp[base+k] - last_act >= TB_RCD, "R9", "open-to-read gap",
                stamp[base+k] - last_act, TB_RCD);
          check(stamp[base+k] - last_wr >= TB_WTR, "R8", "write-to-read gap",
                stamp[base+k] - last_wr, TB_WTR);
        end
        2'd2: begin
          check(stamp[base+k] - last_act >= TB_RCD, "R9", "open-to-write gap",
                stamp[base+k] - last_act, TB_RCD);
          last_wr = stamp[base+k];
        end
        default: last_pre = stamp[base+k];
      endcase
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    // scenario 0: keep-open; R1 hit D served before older miss C,
    // R3 column before row commands, R4 close/open only on conflict
    start_sc(1'b0);
    base = log_n;
    push(1'b0, 5, 1);
    push(1'b1, 5, 2);
    push(1'b0, 7, 3);
    push(1'b0, 5, 4);
    repeat (30) @(negedge clk);
    verify(0, base, "R1/R3/R4/R6");
    if (log_n - base >= 4)
      check(stamp[base+3] - stamp[base+2] == TB_WTR, "R8", "read waits exactly after write",
            stamp[base+3] - stamp[base+2], TB_WTR);

    // scenario 1: close policy; R5 keeps row while a hit is queued
    start_sc(1'b1);
    base = log_n;
    push(1'b0, 3, 0);
    push(1'b0, 3, 1);
    repeat (12) @(negedge clk);
    push(1'b1, 9, 5);
    push(1'b0, 11, 2);
    repeat (30) @(negedge clk);
    verify(1, base, "R5/R6");
    if (log_n - base >= 8)
      check(stamp[base+7] - stamp[base+4] == TB_RC, "R7", "open-to-open held to T_RC",
            stamp[base+7] - stamp[base+4], TB_RC);

    // scenario 2: fill the pool; R10 ready low and offered request dropped,
    // R2 misses served in arrival order
    start_sc(1'b0);
    base = log_n;
    push(1'b0, 1, 0);
    push(1'b0, 2, 1);
    push(1'b0, 3, 2);
    push(1'b0, 4, 3);
    push(1'b0, 6, 4);
    check(req_ready == 1'b0, "R10", "ready low when pool full", int'(req_ready), 0);
    push(1'b1, 15, 9);
    repeat (60) @(negedge clk);
    verify(2, base, "R2/R4/R10");
    check(req_ready == 1'b1, "R10", "ready back after drain", int'(req_ready), 1);
    check(cmd_valid == 1'b0, "R4", "open row left open when idle", int'(cmd_valid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule